// File: doc/BRIEF.md
# Masked Round-Robin Channel Scanner

This block picks which channel of a sixteen-channel acquisition front end is serviced next. A sixteen-bit mask, one bit per channel, says which channels take part in the scan. On every clock edge where the advance input is high, the block moves its four-bit channel index to the next enabled channel above the current one. After the highest enabled channel it wraps back to the lowest. When advance is low the index stays where it is.

A sweep-start flag is high while the index sits on the lowest enabled channel. Downstream logic uses it to mark where each pass over the enabled set begins. A valid flag tells whether the channel under the index is currently enabled.

The mask may change at any time. The scan follows the new mask from its current position. Reset is synchronous and puts the index on the lowest enabled channel.

Top module: `chan_scanner`

## Requirements
- R1: While reset is high at a rising clock edge, the index loads the lowest set bit position of the mask seen at that edge, or 0 if the mask is all zeros.
- R2: With advance high and the mask unchanged, successive indices visit only positions whose mask bit is 1, in ascending order. With mask 16'hC6C6 the visit order is 1, 2, 6, 7, 9, 10, 14, 15.
- R3: After the highest set bit position, the next advance goes to the lowest set bit position. With mask 16'hC6C6, index 15 is followed by 1.
- R4: At a clock edge where reset and advance are both low, the index keeps its value, whatever the mask does.
- R5: sweepStart is 1 exactly when the mask is non-zero and the index equals the lowest set bit position of the current mask. Otherwise it is 0.
- R6: With exactly one mask bit set, advancing keeps the index on that bit, and sweepStart stays 1.
- R7: On an advance, the new index is the lowest set bit strictly above the old index in the mask seen at that edge. If no such bit exists, it is the lowest set bit of that mask. This also holds when the mask changes in the middle of a sweep.
- R8: With an all-zero mask, an advance sets the index to 0, and both sweepStart and chanValid are 0.
- R9: chanValid equals the mask bit at the position given by the index (1 = the channel is enabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Lets the scan step one enabled channel per edge |
| chanMask | input | 16 | Channel enable mask, bit n enables channel n |
| chanIdx | output | 4 | Current channel index |
| sweepStart | output | 1 | High while the index is on the lowest enabled channel |
| chanValid | output | 1 | Mask bit of the current channel |

## Verification
The only state is the index register, so a wrong internal state shows at the ports as a wrong chanIdx on the very edge that produced it. A fault in how the next channel is chosen, such as a skipped, repeated or out-of-order channel or a missed wrap, becomes visible one cycle after the faulty advance. The flags derive from the index and the live mask with no added latency. Because of that, a stuck or mis-decoded sweepStart or chanValid can be seen in the same cycle as the index it disagrees with. A mask that changes between edges reaches the flags at once and reaches the index at the next advance, so each step is checked against the mask present at that edge.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Command strobes from the scan control to the index datapath.
  typedef struct packed {
    logic loadBase;   // load the lowest enabled channel
    logic step;       // move to the next enabled channel
    logic clearIdx;   // park the index on channel 0
  } scanCmd_t;

endpackage

// File: rtl/scan_lowpick.sv
module scan_lowpick #(
  parameter int NUM_CH = 16,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] vecIn,
  output logic [IDX_W-1:0]  lowIdx,
  output logic              found
);

  logic [NUM_CH:0]   seenBelow;
  logic [NUM_CH-1:0] firstHot;

  assign seenBelow[0] = 1'b0;

  // Prefix chain: a bit wins when no lower bit is set.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chain
    assign seenBelow[g+1] = seenBelow[g] | vecIn[g];
    assign firstHot[g]    = vecIn[g] & ~seenBelow[g];
  end

  always_comb begin
    lowIdx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (firstHot[i]) lowIdx = lowIdx | IDX_W'(i);
    end
  end

  assign found = seenBelow[NUM_CH];

endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
(
  input  logic     rst,
  input  logic     advance,
  input  logic     maskAny,
  output scanCmd_t cmd
);

  always_comb begin
    cmd = '0;
    if (rst) begin
      cmd.loadBase = 1'b1;
    end else if (advance) begin
      if (maskAny) cmd.step     = 1'b1;
      else         cmd.clearIdx = 1'b1;
    end
  end

endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  scanCmd_t          cmd,
  input  logic [NUM_CH-1:0] chanMask,
  output logic [IDX_W-1:0]  chanIdx,
  output logic              sweepStart,
  output logic              chanValid,
  output logic              maskAny
);

  logic [IDX_W-1:0]  idxQ;
  logic [NUM_CH-1:0] aboveMask;
  logic [IDX_W-1:0]  baseIdx;
  logic [IDX_W-1:0]  aboveIdx;
  logic              aboveAny;
  logic [IDX_W-1:0]  stepIdx;

  // Keep only enabled channels strictly above the current index.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_above
    assign aboveMask[g] = chanMask[g] && (IDX_W'(g) > idxQ);
  end

  scan_lowpick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) i_baseSel (
    .vecIn (chanMask),
    .lowIdx(baseIdx),
    .found (maskAny)
  );

  scan_lowpick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) i_aboveSel (
    .vecIn (aboveMask),
    .lowIdx(aboveIdx),
    .found (aboveAny)
  );

  assign stepIdx = aboveAny ? aboveIdx : baseIdx;

  always_ff @(posedge clk) begin
    if (cmd.loadBase)      idxQ <= baseIdx;
    else if (cmd.step)     idxQ <= stepIdx;
    else if (cmd.clearIdx) idxQ <= '0;
  end

  assign chanIdx    = idxQ;
  assign sweepStart = maskAny && (idxQ == baseIdx);
  assign chanValid  = chanMask[idxQ];

endmodule

// File: rtl/chan_scanner.sv
module chan_scanner
  import scan_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic [NUM_CH-1:0] chanMask,
  output logic [IDX_W-1:0]  chanIdx,
  output logic              sweepStart,
  output logic              chanValid
);

  scanCmd_t cmd;
  logic     maskAny;

  scan_ctrl i_ctrl (
    .rst    (rst),
    .advance(advance),
    .maskAny(maskAny),
    .cmd    (cmd)
  );

  scan_datapath #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) i_dp (
    .clk       (clk),
    .cmd       (cmd),
    .chanMask  (chanMask),
    .chanIdx   (chanIdx),
    .sweepStart(sweepStart),
    .chanValid (chanValid),
    .maskAny   (maskAny)
  );

endmodule

// File: rtl/chan_scanner_chk.sv
module chan_scanner_chk #(
  parameter int NUM_CH = 16,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst,
  input logic              advance,
  input logic [NUM_CH-1:0] chanMask,
  input logic [IDX_W-1:0]  chanIdx,
  input logic              sweepStart,
  input logic              chanValid
);

  logic [NUM_CH-1:0] prevMask;
  logic [IDX_W-1:0]  prevIdx;

  always_ff @(posedge clk) begin
    prevMask <= chanMask;
    prevIdx  <= chanIdx;
  end

  function automatic logic [IDX_W-1:0] lowOf(input logic [NUM_CH-1:0] m);
    lowOf = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (m[i]) lowOf = IDX_W'(i);
    end
  endfunction

  // R1: reset lands on the lowest enabled channel of the mask at that edge
  p_reset_base_r1: assert property (@(posedge clk)
    rst |=> chanIdx == lowOf(prevMask));

  // R3 and R7: an advance lands on an enabled channel, upward or wrapped to the lowest
  p_step_lands_r3: assert property (@(posedge clk) disable iff (rst)
    (advance && (chanMask != '0)) |=>
      (prevMask[chanIdx] && ((chanIdx > prevIdx) || (chanIdx == lowOf(prevMask)))));

  // R4: no advance, no movement
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(chanIdx));

  // R5: sweep start only on an enabled channel
  p_first_valid_r5: assert property (@(posedge clk) disable iff (rst)
    sweepStart |-> chanValid);

  // R6: a single enabled channel keeps the sweep flag up after an advance
  p_single_stays_r6: assert property (@(posedge clk) disable iff (rst)
    (advance && ($countones(chanMask) == 1)) |=> (sweepStart || (chanMask != prevMask)));

  // R8: empty mask reports nothing
  p_empty_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (chanMask == '0) |-> (!sweepStart && !chanValid));

  // R8: advancing with an empty mask parks the index on 0
  p_empty_park_r8: assert property (@(posedge clk) disable iff (rst)
    (advance && (chanMask == '0)) |=> (chanIdx == '0));

endmodule

bind chan_scanner chan_scanner_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .advance   (advance),
  .chanMask  (chanMask),
  .chanIdx   (chanIdx),
  .sweepStart(sweepStart),
  .chanValid (chanValid)
);

// File: tb/test_chan_scanner.sv
`timescale 1ns/1ps
module test_chan_scanner;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        advance = 1'b0;
  logic [15:0] chanMask = 16'hC6C6;
  logic [3:0]  chanIdx;
  logic        sweepStart;
  logic        chanValid;

  int total = 0;
  int bad   = 0;
  int expIdx = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  chan_scanner i_chan_scanner (
    .clk       (clk),
    .rst       (rst),
    .advance   (advance),
    .chanMask  (chanMask),
    .chanIdx   (chanIdx),
    .sweepStart(sweepStart),
    .chanValid (chanValid)
  );

  function automatic int lowBit(input logic [15:0] m);
    for (int i = 0; i < 16; i++) if (m[i]) return i;
    return 0;
  endfunction

  function automatic int nextBit(input logic [15:0] m, input int cur);
    if (m == 16'h0) return 0;
    for (int i = cur + 1; i < 16; i++) if (m[i]) return i;
    return lowBit(m);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, update the model, sample after the rising edge.
  task automatic cyc(input logic r, input logic a, input logic [15:0] m, input string tag);
    int nxt;
    @(negedge clk);
    rst = r; advance = a; chanMask = m;
    if (r)      nxt = lowBit(m);
    else if (a) nxt = nextBit(m, expIdx);
    else        nxt = expIdx;
    @(posedge clk);
    #1;
    expIdx = nxt;
    check({tag, " index"}, int'(chanIdx), expIdx);
    check("R5 sweepStart", int'(sweepStart), int'((m != 0) && (expIdx == lowBit(m))));
    check("R9 chanValid", int'(chanValid), int'(m[expIdx]));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset places the index on channel 1 of C6C6
    cyc(1, 0, 16'hC6C6, "R1");
    cyc(1, 0, 16'hC6C6, "R1");
    // R2 and R3: ascending visit 1,2,6,7,9,10,14,15 then wrap to 1
    for (int k = 0; k < 18; k++) cyc(0, 1, 16'hC6C6, k % 8 == 7 ? "R3" : "R2");
    // R4: hold with advance low, also while the mask moves
    for (int k = 0; k < 4; k++) cyc(0, 0, 16'hC6C6 ^ 16'(k * 4369), "R4");
    for (int k = 0; k < 5; k++) cyc(0, 1, 16'hC6C6, "R2");
    // R1: reset in the middle of a sweep
    cyc(1, 1, 16'hC6C6, "R1");
    cyc(0, 1, 16'hC6C6, "R2");
    // R6: every single-bit mask, reached from reset and by a live change
    for (int b = 0; b < 16; b++) begin
      cyc(1, 0, 16'(1) << b, "R1");
      for (int k = 0; k < 3; k++) cyc(0, 1, 16'(1) << b, "R6");
      cyc(0, 1, 16'(1) << ((b + 5) % 16), "R7");
      cyc(0, 1, 16'(1) << ((b + 5) % 16), "R6");
    end
    // R7: masks 0009 and 8002 changed mid-sweep
    cyc(1, 0, 16'hFFFF, "R1");
    for (int k = 0; k < 2; k++) cyc(0, 1, 16'hFFFF, "R2");
    for (int k = 0; k < 4; k++) cyc(0, 1, 16'h0009, "R7");
    for (int k = 0; k < 4; k++) cyc(0, 1, 16'h8002, "R7");
    // R8: empty mask parks at 0 with both flags low
    for (int k = 0; k < 3; k++) cyc(0, 1, 16'h0000, "R8");
    cyc(0, 0, 16'h0000, "R8");
    cyc(1, 0, 16'h0000, "R1");
    // R7: scrambled masks changing every few cycles, advance pattern varies
    for (int k = 0; k < 600; k++) begin
      logic [15:0] m;
      m = 16'(k * 40503 + 977);
      if (k % 23 == 0) m = 16'h0;
      for (int j = 0; j < 8; j++) cyc(0, ((k + j) % 3) != 0, m, "R7");
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule